// File: doc/BRIEF.md
# Page Ownership Guard

This block keeps one record for each 4 KiB physical page that can be handed to a guest. Each record says whether the page is assigned, which address-space ID owns it, which guest-physical page number the owner is expected to reach it through, and whether the owner has accepted it. The hypervisor writes records through a command port that assigns or releases a page. A guest accepts an assigned page through a second command port.

A third port judges one memory access in the same cycle. The caller presents the physical page, the requester's ID, the guest-physical page it used, whether the access writes, and whether protection applies to it. The block returns a two-bit verdict. Requester ID 0 stands for the hypervisor, and every other ID is a guest. A write covers both ordinary stores and accessed/dirty flag updates made during a page-table walk. The caller raises the write input for either kind.

Verdict codes: 0 = allow, 1 = owner or mapping mismatch, 2 = page not yet accepted by its owner, 3 = hypervisor write to an assigned page.

Top module: `page_owner_guard`

## Requirements
- R1: After reset every record is unassigned and not accepted. A protected guest access to any page then returns 1, and a protected hypervisor write returns 0.
- R2: With `chk_prot_en` = 0 the verdict is 0 for any page, requester, mapping and direction.
- R3: A protected guest access returns 1 unless the record is assigned, its owner equals `chk_asid` and its guest page equals `chk_gpn`. The verdict is combinational in the same cycle as the inputs.
- R4: An assign command (`hv_cmd_assign` = 1) makes the record assigned, with the given owner and guest page, and clears its accepted bit from the next clock edge on. A release command (`hv_cmd_assign` = 0) returns the record to the reset state.
- R5: A guest accept command succeeds when all of the following hold: the caller is a guest, the page is assigned to it, the guest page matches, and the page is not yet accepted. On success `gv_cmd_ok` is 1 in that cycle and the accepted bit is set from the next edge.
- R6: A protected guest access that passes the R3 test returns 2 while the accepted bit is 0 and returns 0 once it is 1.
- R7: For a guest, the verdict does not depend on `chk_write`. A store and a page-walk flag update both give the same verdict as a read.
- R8: A protected hypervisor access (`chk_asid` = 0) returns 0 for a read. It returns 3 for a write to an assigned page and 0 for a write to an unassigned page.
- R9: An accept command that does not meet the R5 conditions gives `gv_cmd_ok` = 0 and leaves the record unchanged. This covers a page already accepted, a page not owned by the caller, a mismatched guest page, an unassigned page, and a caller with ID 0.
- R10: When a hypervisor command and a guest accept target the same page in one cycle, the hypervisor command takes effect and `gv_cmd_ok` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hv_cmd_valid | input | 1 | Hypervisor command strobe |
| hv_cmd_assign | input | 1 | 1 = assign page, 0 = release page |
| hv_cmd_ppn | input | PPN_W | Physical page targeted by the hypervisor command |
| hv_cmd_asid | input | 4 | Owner ID to record |
| hv_cmd_gpn | input | 12 | Guest page to record |
| gv_cmd_valid | input | 1 | Guest accept strobe |
| gv_cmd_ppn | input | PPN_W | Physical page to accept |
| gv_cmd_asid | input | 4 | ID of the accepting guest |
| gv_cmd_gpn | input | 12 | Guest page the guest believes maps there |
| gv_cmd_ok | output | 1 | Accept command succeeded |
| chk_ppn | input | PPN_W | Physical page of the access |
| chk_asid | input | 4 | Requester ID, 0 = hypervisor |
| chk_gpn | input | 12 | Guest page used by the access |
| chk_write | input | 1 | Access writes (store or walk flag update) |
| chk_prot_en | input | 1 | Access comes from a protected context |
| chk_fault | output | 2 | Verdict code |

## Verification
Several properties are checked on every cycle. An unprotected access is never refused. Verdict 3 appears only for an ID-0 write, and verdict 2 only for a guest. A successful accept sets the accepted bit at the next edge, and a failed one leaves the record untouched. An assign always leaves an assigned record whose accepted bit is clear. The bench scenarios cover the rest: the reset contents, the exact verdict for each combination of owner, mapping and state, write-versus-read equivalence, and the same-cycle command collision. These are compared against a reference record table kept in the bench.

// File: rtl/pog_pkg.sv
package pog_pkg;
    parameter int unsigned ASID_W = 4;
    parameter int unsigned GPN_W  = 12;

    localparam logic [ASID_W-1:0] HV_ASID = '0;

    typedef struct packed {
        logic              assigned;
        logic [ASID_W-1:0] owner;
        logic [GPN_W-1:0]  gpn;
        logic              accepted;
    } pog_entry_t;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_MISMATCH = 2'd1,
        FLT_UNACCEPT = 2'd2,
        FLT_HV_WRITE = 2'd3
    } pog_fault_e;
endpackage

// File: rtl/pog_table.sv
module pog_table
    import pog_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 16,
    parameter int unsigned PPN_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_we,
    input  logic              hv_assign,
    input  logic [PPN_W-1:0]  hv_ppn,
    input  logic [ASID_W-1:0] hv_asid,
    input  logic [GPN_W-1:0]  hv_gpn,
    input  logic              gv_we,
    input  logic [PPN_W-1:0]  gv_ppn,
    output pog_entry_t        ent_q [NUM_PAGES]
);
    typedef struct packed {
        pog_entry_t [NUM_PAGES-1:0] ent;
    } tbl_state_t;

    tbl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (gv_we && (hv_ppn != gv_ppn || !hv_we) && gv_ppn == PPN_W'(i)) begin
                state_d.ent[i].accepted = 1'b1;
            end
            if (hv_we && hv_ppn == PPN_W'(i)) begin
                if (hv_assign) begin
                    state_d.ent[i] = '{assigned: 1'b1, owner: hv_asid,
                                       gpn: hv_gpn, accepted: 1'b0};
                end else begin
                    state_d.ent[i] = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_out
        assign ent_q[g] = state_q.ent[g];
    end
endmodule

// File: rtl/pog_access_check.sv
module pog_access_check
    import pog_pkg::*;
(
    input  pog_entry_t        ent,
    input  logic              prot_en,
    input  logic [ASID_W-1:0] asid,
    input  logic [GPN_W-1:0]  gpn,
    input  logic              write,
    output pog_fault_e        fault
);
    always_comb begin
        fault = FLT_NONE;
        if (prot_en) begin
            if (asid == HV_ASID) begin
                if (write && ent.assigned) begin
                    fault = FLT_HV_WRITE;
                end
            end else if (!ent.assigned || ent.owner != asid || ent.gpn != gpn) begin
                fault = FLT_MISMATCH;
            end else if (!ent.accepted) begin
                fault = FLT_UNACCEPT;
            end
        end
    end
endmodule

// File: rtl/pog_accept_gate.sv
module pog_accept_gate
    import pog_pkg::*;
(
    input  logic              req,
    input  pog_entry_t        ent,
    input  logic [ASID_W-1:0] asid,
    input  logic [GPN_W-1:0]  gpn,
    input  logic              hv_same_page,
    output logic              grant
);
    always_comb begin
        grant = req && (asid != HV_ASID) && ent.assigned && (ent.owner == asid)
             && (ent.gpn == gpn) && !ent.accepted && !hv_same_page;
    end
endmodule

// File: rtl/page_owner_guard.sv
module page_owner_guard
    import pog_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 16,
    parameter int unsigned PPN_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_cmd_valid,
    input  logic              hv_cmd_assign,
    input  logic [PPN_W-1:0]  hv_cmd_ppn,
    input  logic [ASID_W-1:0] hv_cmd_asid,
    input  logic [GPN_W-1:0]  hv_cmd_gpn,
    input  logic              gv_cmd_valid,
    input  logic [PPN_W-1:0]  gv_cmd_ppn,
    input  logic [ASID_W-1:0] gv_cmd_asid,
    input  logic [GPN_W-1:0]  gv_cmd_gpn,
    output logic              gv_cmd_ok,
    input  logic [PPN_W-1:0]  chk_ppn,
    input  logic [ASID_W-1:0] chk_asid,
    input  logic [GPN_W-1:0]  chk_gpn,
    input  logic              chk_write,
    input  logic              chk_prot_en,
    output logic [1:0]        chk_fault
);
    pog_entry_t ent_q [NUM_PAGES];
    pog_entry_t chk_ent_d, gv_ent_d;
    pog_fault_e fault_d;
    logic       hv_same_d;
    logic       hv_we_d;

    always_comb begin
        chk_ent_d = '0;
        gv_ent_d  = '0;
        if (int'(chk_ppn) < NUM_PAGES) chk_ent_d = ent_q[chk_ppn];
        if (int'(gv_cmd_ppn) < NUM_PAGES) gv_ent_d = ent_q[gv_cmd_ppn];
        hv_we_d   = hv_cmd_valid && (int'(hv_cmd_ppn) < NUM_PAGES);
        hv_same_d = hv_cmd_valid && (hv_cmd_ppn == gv_cmd_ppn);
    end

    pog_table #(.NUM_PAGES(NUM_PAGES), .PPN_W(PPN_W)) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .hv_we     (hv_we_d),
        .hv_assign (hv_cmd_assign),
        .hv_ppn    (hv_cmd_ppn),
        .hv_asid   (hv_cmd_asid),
        .hv_gpn    (hv_cmd_gpn),
        .gv_we     (gv_cmd_ok),
        .gv_ppn    (gv_cmd_ppn),
        .ent_q     (ent_q)
    );

    pog_access_check i_check (
        .ent     (chk_ent_d),
        .prot_en (chk_prot_en),
        .asid    (chk_asid),
        .gpn     (chk_gpn),
        .write   (chk_write),
        .fault   (fault_d)
    );

    pog_accept_gate i_gate (
        .req          (gv_cmd_valid),
        .ent          (gv_ent_d),
        .asid         (gv_cmd_asid),
        .gpn          (gv_cmd_gpn),
        .hv_same_page (hv_same_d),
        .grant        (gv_cmd_ok)
    );

    assign chk_fault = fault_d;
endmodule

// File: rtl/pog_checker.sv
module pog_checker
    import pog_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 16,
    parameter int unsigned PPN_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hv_cmd_valid,
    input logic              hv_cmd_assign,
    input logic [PPN_W-1:0]  hv_cmd_ppn,
    input logic              gv_cmd_valid,
    input logic [PPN_W-1:0]  gv_cmd_ppn,
    input logic              gv_cmd_ok,
    input logic [ASID_W-1:0] chk_asid,
    input logic              chk_write,
    input logic              chk_prot_en,
    input logic [1:0]        chk_fault,
    input pog_entry_t        ent_q [NUM_PAGES]
);
    // R2: unprotected accesses are never refused
    p_unprot_allow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_prot_en |-> chk_fault == 2'd0);

    // R8: code 3 only for an ID-0 write
    p_hv_write_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fault == 2'd3 |-> (chk_asid == HV_ASID && chk_write && chk_prot_en));

    // R6: code 2 only for a guest
    p_unaccept_guest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fault == 2'd2 |-> chk_asid != HV_ASID);

    // R4: assign leaves an assigned, not accepted record
    p_assign_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_cmd_valid && hv_cmd_assign) |=>
            (ent_q[$past(hv_cmd_ppn)].assigned && !ent_q[$past(hv_cmd_ppn)].accepted));

    // R5: a granted accept sets the accepted bit
    p_accept_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gv_cmd_ok |=> ent_q[$past(gv_cmd_ppn)].accepted);

    // R9: a refused accept leaves its record unchanged
    p_refused_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gv_cmd_valid && !gv_cmd_ok && !(hv_cmd_valid && hv_cmd_ppn == gv_cmd_ppn)) |=>
            ent_q[$past(gv_cmd_ppn)] == $past(ent_q[gv_cmd_ppn]));

    // R10: collision with a hypervisor command is never granted
    p_collision_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_cmd_valid && hv_cmd_ppn == gv_cmd_ppn) |-> !gv_cmd_ok);
endmodule

bind page_owner_guard pog_checker #(.NUM_PAGES(NUM_PAGES), .PPN_W(PPN_W)) i_pog_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .hv_cmd_valid  (hv_cmd_valid),
    .hv_cmd_assign (hv_cmd_assign),
    .hv_cmd_ppn    (hv_cmd_ppn),
    .gv_cmd_valid  (gv_cmd_valid),
    .gv_cmd_ppn    (gv_cmd_ppn),
    .gv_cmd_ok     (gv_cmd_ok),
    .chk_asid      (chk_asid),
    .chk_write     (chk_write),
    .chk_prot_en   (chk_prot_en),
    .chk_fault     (chk_fault),
    .ent_q         (ent_q)
);

// File: tb/test_page_owner_guard.sv
module test_page_owner_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;
    localparam int PW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hv_cmd_valid, hv_cmd_assign;
    logic [PW-1:0] hv_cmd_ppn;
    logic [3:0]  hv_cmd_asid;
    logic [11:0] hv_cmd_gpn;
    logic        gv_cmd_valid;
    logic [PW-1:0] gv_cmd_ppn;
    logic [3:0]  gv_cmd_asid;
    logic [11:0] gv_cmd_gpn;
    logic        gv_cmd_ok;
    logic [PW-1:0] chk_ppn;
    logic [3:0]  chk_asid;
    logic [11:0] chk_gpn;
    logic        chk_write, chk_prot_en;
    logic [1:0]  chk_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit          m_asg [NP];
    logic [3:0]  m_own [NP];
    logic [11:0] m_gpn [NP];
    bit          m_acc [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_owner_guard #(.NUM_PAGES(NP)) i_page_owner_guard (
        .clk(clk), .rst_n(rst_n),
        .hv_cmd_valid(hv_cmd_valid), .hv_cmd_assign(hv_cmd_assign),
        .hv_cmd_ppn(hv_cmd_ppn), .hv_cmd_asid(hv_cmd_asid), .hv_cmd_gpn(hv_cmd_gpn),
        .gv_cmd_valid(gv_cmd_valid), .gv_cmd_ppn(gv_cmd_ppn),
        .gv_cmd_asid(gv_cmd_asid), .gv_cmd_gpn(gv_cmd_gpn), .gv_cmd_ok(gv_cmd_ok),
        .chk_ppn(chk_ppn), .chk_asid(chk_asid), .chk_gpn(chk_gpn),
        .chk_write(chk_write), .chk_prot_en(chk_prot_en), .chk_fault(chk_fault)
    );

    function automatic logic [1:0] exp_fault();
        int p = int'(chk_ppn);
        if (!chk_prot_en) return 2'd0;
        if (chk_asid == 4'd0) return (chk_write && m_asg[p]) ? 2'd3 : 2'd0;
        if (!m_asg[p] || m_own[p] != chk_asid || m_gpn[p] != chk_gpn) return 2'd1;
        return m_acc[p] ? 2'd0 : 2'd2;
    endfunction

    function automatic logic exp_ok();
        int p = int'(gv_cmd_ppn);
        if (!gv_cmd_valid || gv_cmd_asid == 4'd0) return 1'b0;
        if (hv_cmd_valid && hv_cmd_ppn == gv_cmd_ppn) return 1'b0;
        return m_asg[p] && m_own[p] == gv_cmd_asid && m_gpn[p] == gv_cmd_gpn && !m_acc[p];
    endfunction

    task automatic check(input bit cond, input string tag, input int act, input int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic idle();
        hv_cmd_valid = 0; hv_cmd_assign = 0; hv_cmd_ppn = '0; hv_cmd_asid = '0; hv_cmd_gpn = '0;
        gv_cmd_valid = 0; gv_cmd_ppn = '0; gv_cmd_asid = '0; gv_cmd_gpn = '0;
        chk_ppn = '0; chk_asid = '0; chk_gpn = '0; chk_write = 0; chk_prot_en = 0;
    endtask

    task automatic access(input int p, input int a, input int g, input bit w, input bit pe);
        chk_ppn = PW'(p); chk_asid = 4'(a); chk_gpn = 12'(g); chk_write = w; chk_prot_en = pe;
    endtask

    // inputs set at negedge; sample, then clock, then update the model
    task automatic step(input string tag);
        logic [1:0] ef;
        logic eo;
        #1;
        ef = exp_fault();
        eo = exp_ok();
        check(chk_fault == ef, {tag, " verdict"}, int'(chk_fault), int'(ef));
        check(gv_cmd_ok == eo, {tag, " accept"}, int'(gv_cmd_ok), int'(eo));
        @(posedge clk);
        if (eo) m_acc[gv_cmd_ppn] = 1;
        if (hv_cmd_valid) begin
            m_asg[hv_cmd_ppn] = hv_cmd_assign;
            m_own[hv_cmd_ppn] = hv_cmd_assign ? hv_cmd_asid : 4'd0;
            m_gpn[hv_cmd_ppn] = hv_cmd_assign ? hv_cmd_gpn : 12'd0;
            m_acc[hv_cmd_ppn] = 0;
        end
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        for (int i = 0; i < NP; i++) begin
            m_asg[i] = 0; m_own[i] = 0; m_gpn[i] = 0; m_acc[i] = 0;
        end
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset contents
        access(5, 1, 0, 0, 1); step("R1 guest after reset");
        access(5, 0, 0, 1, 1); step("R1 hv write after reset");
        // R2: protection off
        access(5, 2, 9, 1, 0); step("R2 unprotected");

        // R4: assign page 5 to ID 2 at guest page 7
        hv_cmd_valid = 1; hv_cmd_assign = 1; hv_cmd_ppn = 4'd5; hv_cmd_asid = 4'd2; hv_cmd_gpn = 12'd7;
        step("R4 assign");
        access(5, 2, 7, 0, 1); step("R6 not accepted");
        access(5, 1, 7, 0, 1); step("R3 wrong owner");
        access(5, 2, 8, 0, 1); step("R3 wrong guest page");
        access(5, 0, 0, 0, 1); step("R8 hv read");
        access(5, 0, 0, 1, 1); step("R8 hv write");

        // R9: accept by non-owner
        gv_cmd_valid = 1; gv_cmd_ppn = 4'd5; gv_cmd_asid = 4'd1; gv_cmd_gpn = 12'd7;
        access(5, 2, 7, 0, 1); step("R9 non-owner accept");
        gv_cmd_valid = 1; gv_cmd_ppn = 4'd5; gv_cmd_asid = 4'd2; gv_cmd_gpn = 12'd9;
        step("R9 mapping mismatch accept");
        // R5: proper accept
        gv_cmd_valid = 1; gv_cmd_ppn = 4'd5; gv_cmd_asid = 4'd2; gv_cmd_gpn = 12'd7;
        step("R5 accept");
        access(5, 2, 7, 0, 1); step("R6 accepted read");
        access(5, 2, 7, 1, 1); step("R7 write same as read");
        gv_cmd_valid = 1; gv_cmd_ppn = 4'd5; gv_cmd_asid = 4'd2; gv_cmd_gpn = 12'd7;
        access(5, 2, 7, 1, 1); step("R9 second accept");

        // R10: collision
        hv_cmd_valid = 1; hv_cmd_assign = 1; hv_cmd_ppn = 4'd6; hv_cmd_asid = 4'd3; hv_cmd_gpn = 12'd1;
        step("R4 assign page 6");
        hv_cmd_valid = 1; hv_cmd_assign = 1; hv_cmd_ppn = 4'd6; hv_cmd_asid = 4'd3; hv_cmd_gpn = 12'd1;
        gv_cmd_valid = 1; gv_cmd_ppn = 4'd6; gv_cmd_asid = 4'd3; gv_cmd_gpn = 12'd1;
        step("R10 collision");
        access(6, 3, 1, 0, 1); step("R10 page 6 still unaccepted");

        // R4: release page 5
        hv_cmd_valid = 1; hv_cmd_assign = 0; hv_cmd_ppn = 4'd5;
        step("R4 release");
        access(5, 2, 7, 0, 1); step("R4 released guest");
        access(5, 0, 0, 1, 1); step("R8 hv write unassigned");

        // random mix against the model (R3 R6 R7 R8 R9 R5)
        for (int n = 0; n < 600; n++) begin
            hv_cmd_valid  = ($urandom % 5) == 0;
            hv_cmd_assign = ($urandom % 4) != 0;
            hv_cmd_ppn    = PW'($urandom % NP);
            hv_cmd_asid   = 4'(1 + $urandom % 3);
            hv_cmd_gpn    = 12'($urandom % 4);
            gv_cmd_valid  = ($urandom % 2) == 0;
            gv_cmd_ppn    = PW'($urandom % NP);
            gv_cmd_asid   = 4'($urandom % 4);
            gv_cmd_gpn    = 12'($urandom % 4);
            access($urandom % NP, $urandom % 4, $urandom % 4, 1'($urandom % 2), ($urandom % 8) != 0);
            step("R3 R6 R8 R5 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule